// File: doc/BRIEF.md
# Power Management Interrupt Controller

This block gathers power-management events from several places and turns them into a single active-low management interrupt for the processor. The events come from three kinds of source:

- five hardware interrupt lines;
- a one-cycle expiry pulse from a separate idle-timer block;
- an external active-low request pin, for example a front-panel button.

Software can also raise an event by writing to a command mailbox register.

Every source passes through its own enable bit before it can record a status bit. A global enable then gates the interrupt pin for all sources together. Status bits are sticky, and the interrupt handler clears them by writing ones. A second mailbox register, for status and data, lets software pass a byte to the handler without raising anything.

The hardware lines and the external pin are asynchronous to the block. Each one passes through a synchronizer and then an edge detector, so one assertion of a line produces exactly one event. The controller takes no account of any power state: an enabled event always records and, if the global gate is open, always interrupts.

Top module: `pm_irq_ctrl`

## Requirements
- R1: After reset, `mgmt_irq_n` is 1 and every register reads 0.
- R2: The status bits map to sources as follows:
  - bit0: line 1; bit1: line 3; bit2: line 4; bit3: line 8; bit4: line 12 (these are `irq_line_i[0..4]`);
  - bit5: the timer pulse; bit6: the external pin; bit7: a command write.
  - Line 8 and the external pin are active-low; the other lines are active-high.
  - A line or pin event is its inactive-to-active transition, recorded three clock edges after it appears at the pin.
- R3: A source whose bit in the enable mask (address 0) is 0 sets no status bit and causes no interrupt.
- R4: `mgmt_irq_n` is 0 exactly when the global enable (address 1, bit 0) is 1 and some status bit that is also enabled is set. Status bits still record while the global enable is 0.
- R5: Status bits (address 2) are sticky: they stay set after the source returns to inactive.
- R6: Writing to address 2 clears each status bit written with 1 and leaves bits written with 0 unchanged.
- R7: When an event and a write-1-to-clear of the same bit fall in one cycle, the bit stays set.
- R8: Any write to the command mailbox (address 3) sets status bit7 on that clock edge when bit7 is enabled. The written byte reads back from address 3.
- R9: A write to the data mailbox (address 4) never changes status or the interrupt, and the byte reads back from address 4.
- R10: A one-cycle `timer_expired` pulse sets status bit5 on the next clock edge.
- R11: A line held active yields one event only: after its bit is cleared, it does not set again until the line goes inactive and then active again.
- R12: Read data is combinational from `bus_addr`; unused addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_line_i | input | 5 | Hardware interrupt lines 1, 3, 4, 8 (active-low), 12 |
| ext_req_n | input | 1 | External active-low request pin |
| timer_expired | input | 1 | One-cycle idle-timer expiry pulse |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| mgmt_irq_n | output | 1 | Active-low management interrupt |

## Verification
Assertions check, on every cycle:
- that each enabled event is present in status on the following edge, even against a clear;
- that no status bit rises without an enabled event behind it;
- that a write-1-to-clear with no competing event empties its bits;
- that edge pulses last a single cycle;
- that the interrupt pin stays high while the global gate is closed.

Some behaviours only the bench scenarios can show. These are the exact pin-to-status latency through the synchronizers, the polarity of line 8 and the external pin, and the mailbox read-back. Also bench-only are the gate opening after events recorded while it was closed, and a held line producing no second event.

// File: rtl/pmic_pkg.sv
package pmic_pkg;

    localparam int NUM_HW   = 5;
    localparam int NUM_SRC  = NUM_HW + 3;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 3;

    localparam int SRC_TIMER = NUM_HW;
    localparam int SRC_EXT   = NUM_HW + 1;
    localparam int SRC_CMD   = NUM_HW + 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_MASK = 3'd0,
        ADR_CTRL = 3'd1,
        ADR_STAT = 3'd2,
        ADR_CMD  = 3'd3,
        ADR_DATA = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic [NUM_SRC-1:0] src_mask;
        logic               glb_en;
    } ctrl_t;

    function automatic logic wr_hit(input bus_req_t r, input reg_addr_e a);
        return r.valid && r.write && (r.addr == a);
    endfunction

endpackage

// File: rtl/pmic_edge_sync.sv
module pmic_edge_sync #(
    parameter int             WIDTH      = 1,
    parameter int             STAGES     = 2,
    parameter logic [WIDTH-1:0] ACTIVE_LOW = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] pulse
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        localparam logic IDLE = ACTIVE_LOW[g];
        logic [STAGES-1:0] chain;
        logic              prev;
        logic              act_now, act_prev;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= {STAGES{IDLE}};
                prev  <= IDLE;
            end else begin
                chain <= {chain[STAGES-2:0], din[g]};
                prev  <= chain[STAGES-1];
            end
        end

        assign act_now  = chain[STAGES-1] ^ IDLE;
        assign act_prev = prev ^ IDLE;
        assign pulse[g] = act_now & ~act_prev;

        // R11: one transition gives a single-cycle event
        assert_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
            pulse[g] |=> !pulse[g]);
    end
endmodule

// File: rtl/pmic_regs.sv
module pmic_regs
    import pmic_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  bus_req_t           req,
    input  logic [NUM_SRC-1:0] status_q,
    output ctrl_t              ctrl,
    output logic               cmd_wr,
    output logic [NUM_SRC-1:0] clr_mask,
    output logic [DATA_W-1:0]  rdata
);
    logic [DATA_W-1:0] cmd_q, data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            cmd_q  <= '0;
            data_q <= '0;
        end else begin
            if (wr_hit(req, ADR_MASK)) ctrl.src_mask <= req.wdata[NUM_SRC-1:0];
            if (wr_hit(req, ADR_CTRL)) ctrl.glb_en   <= req.wdata[0];
            if (wr_hit(req, ADR_CMD))  cmd_q         <= req.wdata;
            if (wr_hit(req, ADR_DATA)) data_q        <= req.wdata;
        end
    end

    assign cmd_wr   = wr_hit(req, ADR_CMD);
    assign clr_mask = wr_hit(req, ADR_STAT) ? req.wdata[NUM_SRC-1:0] : '0;

    always_comb begin
        rdata = '0;
        case (req.addr)
            ADR_MASK: rdata = ctrl.src_mask;
            ADR_CTRL: rdata = {{(DATA_W-1){1'b0}}, ctrl.glb_en};
            ADR_STAT: rdata = status_q;
            ADR_CMD:  rdata = cmd_q;
            ADR_DATA: rdata = data_q;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/pmic_status.sv
module pmic_status
    import pmic_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] events,
    input  ctrl_t              ctrl,
    input  logic [NUM_SRC-1:0] clr_mask,
    output logic [NUM_SRC-1:0] status_q,
    output logic               irq_n
);
    logic [NUM_SRC-1:0] set_vec;

    assign set_vec = events & ctrl.src_mask;

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (status_q & ~clr_mask) | set_vec;
    end

    assign irq_n = ~(ctrl.glb_en & |(status_q & ctrl.src_mask));

    // R7: an enabled event is recorded even against a clear
    assert_event_sets_status_R7: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

    // R3: no status bit rises without an enabled event
    assert_masked_src_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        ((status_q & ~$past(status_q) & ~$past(set_vec)) == '0));

    // R6: clearing without a competing event empties the bits
    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (rst)
        ((clr_mask & ~set_vec) != '0) |=> ((status_q & $past(clr_mask & ~set_vec)) == '0));

    // R4: a low interrupt always has a recorded cause
    assert_irq_has_cause_R4: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> (status_q != '0));
endmodule

// File: rtl/pm_irq_ctrl.sv
module pm_irq_ctrl
    import pmic_pkg::*;
#(
    parameter int                SYNC_STAGES   = 2,
    parameter logic [NUM_HW-1:0] HW_ACTIVE_LOW = 5'b01000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_HW-1:0] irq_line_i,
    input  logic              ext_req_n,
    input  logic              timer_expired,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              mgmt_irq_n
);
    bus_req_t           req;
    ctrl_t              ctrl;
    logic [NUM_HW-1:0]  hw_pulse;
    logic               ext_pulse;
    logic               cmd_wr;
    logic [NUM_SRC-1:0] clr_mask, status_q, events;

    assign req = '{valid: bus_valid, write: bus_write, addr: bus_addr, wdata: bus_wdata};

    pmic_edge_sync #(.WIDTH(NUM_HW), .STAGES(SYNC_STAGES), .ACTIVE_LOW(HW_ACTIVE_LOW)) hw_sync_i (
        .clk(clk), .rst(rst), .din(irq_line_i), .pulse(hw_pulse));

    pmic_edge_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .ACTIVE_LOW(1'b1)) ext_sync_i (
        .clk(clk), .rst(rst), .din(ext_req_n), .pulse(ext_pulse));

    always_comb begin
        events               = '0;
        events[NUM_HW-1:0]   = hw_pulse;
        events[SRC_TIMER]    = timer_expired;
        events[SRC_EXT]      = ext_pulse;
        events[SRC_CMD]      = cmd_wr;
    end

    pmic_regs regs_i (
        .clk(clk), .rst(rst), .req(req), .status_q(status_q),
        .ctrl(ctrl), .cmd_wr(cmd_wr), .clr_mask(clr_mask), .rdata(bus_rdata));

    pmic_status stat_i (
        .clk(clk), .rst(rst), .events(events), .ctrl(ctrl),
        .clr_mask(clr_mask), .status_q(status_q), .irq_n(mgmt_irq_n));

    // R4: closed global gate keeps the pin high
    assert_global_gate_R4: assert property (@(posedge clk) disable iff (rst)
        !ctrl.glb_en |-> mgmt_irq_n);
endmodule

// File: tb/pm_irq_ctrl_tb.sv
module pm_irq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] irq_line_i = 5'b01000;
    logic       ext_req_n = 1'b1;
    logic       timer_expired = 1'b0;
    logic       bus_valid = 1'b0, bus_write = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       mgmt_irq_n;

    int n_chk = 0, n_bad = 0;
    localparam logic [4:0] IDLE_LINES = 5'b01000;

    always #4 clk = ~clk;

    pm_irq_ctrl dut_i (.*);

    // {enable, global, hw active mask, ext active, exp status, exp irq_n, pad}
    localparam logic [31:0] VEC [8] = '{
        {8'hFF, 1'b1, 5'b00001, 1'b0, 8'h01, 1'b0, 8'h00},
        {8'hFF, 1'b1, 5'b01000, 1'b0, 8'h08, 1'b0, 8'h00},
        {8'hFF, 1'b1, 5'b10010, 1'b1, 8'h52, 1'b0, 8'h00},
        {8'h0F, 1'b1, 5'b11111, 1'b1, 8'h0F, 1'b0, 8'h00},
        {8'hF0, 1'b1, 5'b01111, 1'b0, 8'h00, 1'b1, 8'h00},
        {8'hFF, 1'b0, 5'b00100, 1'b0, 8'h04, 1'b1, 8'h00},
        {8'h40, 1'b1, 5'b00000, 1'b1, 8'h40, 1'b0, 8'h00},
        {8'h00, 1'b1, 5'b11111, 1'b1, 8'h00, 1'b1, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic timer_pulse();
        @(negedge clk); timer_expired = 1'b1;
        @(negedge clk); timer_expired = 1'b0;
    endtask

    logic [7:0] v;

    initial begin
        wait_n(3);
        rst = 1'b0;
        // R1 / R12 reset state and read map
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], v);
            check("R1 R12 reset read", v, 8'h00);
        end
        check("R1 irq after reset", {7'd0, mgmt_irq_n}, 8'h01);

        // Vector table: R2 R3 R4 R5
        for (int k = 0; k < 8; k++) begin
            wr(3'd0, VEC[k][31:24]);
            wr(3'd1, {7'd0, VEC[k][23]});
            @(negedge clk);
            irq_line_i = VEC[k][22:18] ^ IDLE_LINES;
            ext_req_n  = ~VEC[k][17];
            wait_n(5);
            rd(3'd2, v);
            check("R2 R3 status", v, VEC[k][16:9]);
            check("R4 irq pin", {7'd0, mgmt_irq_n}, {7'd0, VEC[k][8]});
            irq_line_i = IDLE_LINES;
            ext_req_n  = 1'b1;
            wait_n(5);
            rd(3'd2, v);
            check("R5 sticky", v, VEC[k][16:9]);
            wr(3'd2, 8'hFF);
        end

        // R4: status recorded with gate closed, then gate opens
        wr(3'd0, 8'hFF); wr(3'd1, 8'h00);
        timer_pulse();
        check("R4 gate closed", {7'd0, mgmt_irq_n}, 8'h01);
        wr(3'd1, 8'h01);
        check("R4 gate opened", {7'd0, mgmt_irq_n}, 8'h00);
        wr(3'd2, 8'hFF);

        // R10: timer pulse visible after one edge
        timer_pulse();
        rd(3'd2, v);
        check("R10 timer", v, 8'h20);

        // R7: event and clear in the same cycle
        @(negedge clk);
        timer_expired = 1'b1;
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 3'd2; bus_wdata = 8'h20;
        @(negedge clk);
        timer_expired = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
        rd(3'd2, v);
        check("R7 event wins", v, 8'h20);
        wr(3'd2, 8'h20);
        rd(3'd2, v);
        check("R7 plain clear", v, 8'h00);

        // R6: partial clear
        @(negedge clk); irq_line_i = 5'b11011; // lines 1,3,12 active
        wait_n(5);
        irq_line_i = IDLE_LINES;
        wr(3'd2, 8'h02);
        rd(3'd2, v);
        check("R6 partial clear", v, 8'h11);
        wr(3'd2, 8'h00);
        rd(3'd2, v);
        check("R6 zero write", v, 8'h11);
        wr(3'd2, 8'hFF);

        // R11: held line gives one event
        @(negedge clk); irq_line_i = 5'b01001;
        wait_n(5);
        wr(3'd2, 8'h01);
        wait_n(5);
        rd(3'd2, v);
        check("R11 held line", v, 8'h00);
        irq_line_i = IDLE_LINES;
        wait_n(4);
        irq_line_i = 5'b01001;
        wait_n(5);
        rd(3'd2, v);
        check("R11 re-edge", v, 8'h01);
        irq_line_i = IDLE_LINES;
        wr(3'd2, 8'hFF);

        // R8: command mailbox
        wr(3'd0, 8'h7F);
        wr(3'd3, 8'h5A);
        rd(3'd2, v);
        check("R8 cmd masked", v, 8'h00);
        wr(3'd0, 8'h80);
        wr(3'd3, 8'hA5);
        rd(3'd2, v);
        check("R8 cmd status", v, 8'h80);
        check("R8 cmd irq", {7'd0, mgmt_irq_n}, 8'h00);
        rd(3'd3, v);
        check("R8 cmd readback", v, 8'hA5);
        wr(3'd2, 8'hFF);

        // R9: data mailbox
        wr(3'd0, 8'hFF);
        wr(3'd4, 8'hC3);
        rd(3'd2, v);
        check("R9 data no status", v, 8'h00);
        check("R9 data no irq", {7'd0, mgmt_irq_n}, 8'h01);
        rd(3'd4, v);
        check("R9 data readback", v, 8'hC3);
        rd(3'd6, v);
        check("R12 unused addr", v, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule